// File: doc/BRIEF.md
# Multi-Framer Control Register Bank

This block holds the control registers for eight identical framer channels that share one synchronous processor port. A 12-bit address is split into a 4-bit framer selector in the upper bits and an 8-bit register index in the lower bits. Each framer owns a private copy of the same register map. The whole contents of the bank are driven out on a flat vector, so that the framer datapaths can read their settings directly.

Writes go to one framer, or to all eight at once when the broadcast selector is used. Reads return the addressed register one cycle after the read strobe. The bank can return to its defaults in three ways: the asynchronous hard reset, a per-framer software reset triggered by clearing a run bit, and a bank-wide reset triggered through a separate global control register.

Top module: `framer_regbank`

## Requirements
- R1: While `rst_n` is low and after it rises, every framer register holds its default value: register index `DFLT_REG` holds `DFLT_VAL`, and all other registers, the global register and `rd_data` hold 0. The defaults are read through the port and are also visible on `cfg`.
- R2: A write with selector `addr[11:8]` = f (0..7) and index `addr[7:0]` below `N_REGS` stores `wr_data` in register index of framer f only. The new value appears on `cfg` at the next clock edge.
- R3: A write with selector `4'b1000` stores `wr_data` at the given index in all eight framers at the same clock edge.
- R4: A read with selector `4'b1000` returns framer 0's value at that index.
- R5: `rd_data` takes the addressed value at the clock edge where `rd_en` is sampled high, so it is valid one cycle after the strobe. It holds its value in every cycle without `rd_en`. A read and a write in the same cycle return the value from before the write.
- R6: Bit 0 of register index 0 in each framer is a run bit. A write to that framer (direct or broadcast) that takes this bit from 1 to 0 returns all registers of that framer to their defaults and discards the written data. Other framers are unchanged. Writing 0 when the bit is already 0 is an ordinary write.
- R7: Address `12'hF00` is a global register that reads back the last written value. A write that takes its bit 0 from 1 to 0 returns all registers of all eight framers to their defaults, and the global register stores the written data.
- R8: Writes to selectors 9 to 14, to selector 15 with a nonzero index, or to an index at or above `N_REGS` change nothing. Reads of these addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hard reset, active low |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 12 | Bits 11:8 select the framer (8 = broadcast, 15 = global); bits 7:0 select the register index |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data, registered |
| cfg | output | N_FRAMERS*N_REGS*16 | All framer registers; register r of framer f sits at bit offset (f*N_REGS+r)*16 |

## Verification
The bench builds the bank with the default eight framers, sixteen registers per framer, and a nonzero default placed at index 3. With these values every selector code is legal on the bus: the eight direct codes, broadcast, the unused codes, and the global code. Random indices above 15 exercise the out-of-range decode. Because random data lands on index 0 and on the global register, the run bits rise and fall often. Software and global resets therefore occur many times in the middle of traffic, and the nonzero default shows whether each reset really restored the map.

// File: rtl/framer_regbank.sv
module framer_regbank #(
  parameter int N_FRAMERS = 8,
  parameter int N_REGS    = 16,
  parameter int DW        = 16,
  parameter int AW        = 12,
  parameter int DFLT_REG  = 3,
  parameter logic [15:0] DFLT_VAL = 16'h00A5
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic                           rd_en,
  input  logic [AW-1:0]                  addr,
  input  logic [DW-1:0]                  wr_data,
  output logic [DW-1:0]                  rd_data,
  output logic [N_FRAMERS*N_REGS*DW-1:0] cfg
);
  localparam int FS_W = 4;
  localparam int RX_W = AW - FS_W;
  localparam int FI_W = (N_FRAMERS > 1) ? $clog2(N_FRAMERS) : 1;
  localparam int RI_W = (N_REGS > 1) ? $clog2(N_REGS) : 1;
  localparam logic [FS_W-1:0] SEL_BCAST = 4'b1000;
  localparam logic [FS_W-1:0] SEL_GLOB  = 4'b1111;

  function automatic logic [DW-1:0] dflt(input int r);
    logic [DW-1:0] v;
    v = (r == DFLT_REG) ? DW'(DFLT_VAL) : '0;
    if (r == 0) v[0] = 1'b0;
    return v;
  endfunction

  logic [DW-1:0] regs [N_FRAMERS][N_REGS];
  logic [DW-1:0] glob_q;

  logic [FS_W-1:0] fsel;
  logic [RX_W-1:0] ridx;
  logic            idx_ok, is_bcast, is_glob, is_direct, glob_clear;
  logic [N_FRAMERS-1:0] hit, sw_clear;
  logic [DW-1:0]   rd_val;

  assign fsel      = addr[AW-1:RX_W];
  assign ridx      = addr[RX_W-1:0];
  assign idx_ok    = ridx < RX_W'(N_REGS);
  assign is_bcast  = fsel == SEL_BCAST;
  assign is_glob   = fsel == SEL_GLOB && ridx == '0;
  assign is_direct = fsel < FS_W'(N_FRAMERS);
  assign glob_clear = wr_en && is_glob && glob_q[0] && !wr_data[0];

  for (genvar f = 0; f < N_FRAMERS; f++) begin : g_dec
    assign hit[f]      = wr_en && idx_ok && (is_bcast || fsel == FS_W'(f));
    assign sw_clear[f] = hit[f] && ridx == '0 && regs[f][0][0] && !wr_data[0];
    for (genvar r = 0; r < N_REGS; r++) begin : g_out
      assign cfg[(f*N_REGS+r)*DW +: DW] = regs[f][r];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int f = 0; f < N_FRAMERS; f++)
        for (int r = 0; r < N_REGS; r++)
          regs[f][r] <= dflt(r);
    end else begin
      for (int f = 0; f < N_FRAMERS; f++)
        for (int r = 0; r < N_REGS; r++)
          if (glob_clear || sw_clear[f])
            regs[f][r] <= dflt(r);
          else if (hit[f] && ridx == RX_W'(r))
            regs[f][r] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) glob_q <= '0;
    else if (wr_en && is_glob) glob_q <= wr_data;
  end

  always_comb begin
    rd_val = '0;
    if (is_glob)
      rd_val = glob_q;
    else if (idx_ok && is_direct)
      rd_val = regs[fsel[FI_W-1:0]][ridx[RI_W-1:0]];
    else if (idx_ok && is_bcast)
      rd_val = regs[0][ridx[RI_W-1:0]];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_data <= '0;
    else if (rd_en) rd_data <= rd_val;
  end

  logic [N_FRAMERS-1:0] q_wr, q_sw;
  logic [RI_W-1:0]      q_idx;
  logic [DW-1:0]        q_data;
  logic                 q_bcast, q_glob;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_wr <= '0; q_sw <= '0; q_idx <= '0; q_data <= '0; q_bcast <= 1'b0; q_glob <= 1'b0;
    end else begin
      q_wr    <= hit & ~sw_clear & {N_FRAMERS{!glob_clear}};
      q_sw    <= sw_clear | {N_FRAMERS{glob_clear}};
      q_idx   <= ridx[RI_W-1:0];
      q_data  <= wr_data;
      q_bcast <= wr_en && idx_ok && is_bcast && ridx != '0;
      q_glob  <= wr_en && is_glob;
    end
  end

  p_rd_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));

  p_rd_oob_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !is_glob && !(idx_ok && (is_direct || is_bcast))) |=> rd_data == '0);

  p_glob_store_r7: assert property (@(posedge clk) disable iff (!rst_n)
    q_glob |-> glob_q == q_data);

  for (genvar f = 0; f < N_FRAMERS; f++) begin : g_chk
    p_wr_land_r2: assert property (@(posedge clk) disable iff (!rst_n)
      q_wr[f] |-> regs[f][q_idx] == q_data);
    p_bcast_all_r3: assert property (@(posedge clk) disable iff (!rst_n)
      q_bcast |-> cfg[(f*N_REGS+int'(q_idx))*DW +: DW] == q_data);
    p_sw_dflt_r6: assert property (@(posedge clk) disable iff (!rst_n)
      q_sw[f] |-> (regs[f][0][0] == 1'b0 && regs[f][DFLT_REG] == DW'(DFLT_VAL)));
    p_others_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!hit[f] && !glob_clear) |=> $stable(cfg[f*N_REGS*DW +: N_REGS*DW]));
  end
endmodule

// File: tb/tb_framer_regbank.sv
module tb_framer_regbank;
  localparam int NF = 8;
  localparam int NR = 16;
  localparam int DR = 3;
  localparam logic [15:0] DV = 16'h00A5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [11:0] addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic [NF*NR*16-1:0] cfg;

  framer_regbank #(.N_FRAMERS(NF), .N_REGS(NR), .DFLT_REG(DR), .DFLT_VAL(DV)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .cfg(cfg));

  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  logic [15:0] m [NF][NR];
  logic [15:0] m_glob;
  logic [15:0] last_rd;

  function automatic logic [15:0] dval(input int r);
    return (r == DR) ? DV : 16'h0;
  endfunction

  task automatic model_reset_framer(input int f);
    for (int r = 0; r < NR; r++) m[f][r] = dval(r);
  endtask

  task automatic model_hard_reset();
    for (int f = 0; f < NF; f++) model_reset_framer(f);
    m_glob = '0;
    last_rd = '0;
  endtask

  function automatic logic [15:0] exp_read(input logic [11:0] a);
    int fs, ri;
    fs = int'(a[11:8]); ri = int'(a[7:0]);
    if (fs == 15 && ri == 0) return m_glob;
    if (ri >= NR) return 16'h0;
    if (fs < NF) return m[fs][ri];
    if (fs == 8) return m[0][ri];
    return 16'h0;
  endfunction

  task automatic model_write(input logic [11:0] a, input logic [15:0] d);
    int fs, ri;
    fs = int'(a[11:8]); ri = int'(a[7:0]);
    if (fs == 15 && ri == 0) begin
      if (m_glob[0] && !d[0]) for (int f = 0; f < NF; f++) model_reset_framer(f);
      m_glob = d;
    end else if (ri < NR && (fs < NF || fs == 8)) begin
      for (int f = 0; f < NF; f++)
        if (fs == 8 || fs == f) begin
          if (ri == 0 && m[f][0][0] && !d[0]) model_reset_framer(f);
          else m[f][ri] = d;
        end
    end
  endtask

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [11:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    model_write(a, d);
  endtask

  task automatic do_read(input string req, input logic [11:0] a);
    logic [15:0] e;
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    e = exp_read(a);
    @(negedge clk);
    rd_en = 1'b0;
    last_rd = e;
    check(req, rd_data, e);
  endtask

  task automatic check_cfg(input string req);
    for (int f = 0; f < NF; f++)
      for (int r = 0; r < NR; r++)
        check(req, cfg[(f*NR+r)*16 +: 16], m[f][r]);
  endtask

  function automatic logic [11:0] rand_addr();
    int p;
    logic [3:0] fs;
    logic [7:0] ri;
    p = $urandom_range(0, 99);
    if (p < 60) fs = 4'($urandom_range(0, 7));
    else if (p < 80) fs = 4'h8;
    else if (p < 90) fs = 4'hF;
    else fs = 4'($urandom_range(9, 14));
    if ($urandom_range(0, 9) < 8) ri = 8'($urandom_range(0, NR-1));
    else ri = 8'($urandom_range(NR, 255));
    if (fs == 4'hF && $urandom_range(0, 3) != 0) ri = 8'h00;
    return {fs, ri};
  endfunction

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'h5EED_0042);
    model_hard_reset();
    repeat (3) @(negedge clk);
    // R1: defaults during reset
    check("R1", rd_data, 16'h0);
    check_cfg("R1");
    rst_n = 1'b1;
    for (int f = 0; f < NF; f++)
      for (int r = 0; r < NR; r++) do_read("R1", {4'(f), 8'(r)});
    do_read("R1", 12'hF00);

    // R2: direct write lands in one framer only
    do_write(12'h205, 16'hBEEF);
    check_cfg("R2");
    do_read("R2", 12'h205);
    do_read("R2", 12'h305);

    // R3: broadcast hits all framers in one edge
    do_write(12'h807, 16'h1234);
    check_cfg("R3");
    // R4: broadcast read returns framer 0
    do_write(12'h007, 16'h7777);
    do_read("R4", 12'h807);

    // R5: hold without rd_en, read-during-write returns old value
    do_read("R5", 12'h007);
    do_write(12'h107, 16'h4444);
    check("R5", rd_data, last_rd);
    @(negedge clk);
    rd_en = 1'b1; wr_en = 1'b1; addr = 12'h007; wr_data = 16'hAAAA;
    @(negedge clk);
    rd_en = 1'b0; wr_en = 1'b0;
    check("R5", rd_data, 16'h7777);
    model_write(12'h007, 16'hAAAA);

    // R6: software reset of framer 4 only
    do_write(12'h401, 16'h0101);
    do_write(12'h501, 16'h0202);
    do_write(12'h400, 16'h0001);
    do_write(12'h400, 16'hFFF0);
    check_cfg("R6");
    do_read("R6", 12'h401);
    do_read("R6", 12'h501);
    do_write(12'h400, 16'h0000);
    do_read("R6", 12'h400);

    // R7: global clear
    do_write(12'h633, 16'h0);
    do_write(12'hF00, 16'h0001);
    do_read("R7", 12'hF00);
    do_write(12'hF00, 16'h0C00);
    do_read("R7", 12'hF00);
    check_cfg("R7");

    // R8: ignored addresses
    do_write(12'h905, 16'h5555);
    do_write(12'hF05, 16'h6666);
    do_write(12'h0FF, 16'h7777);
    do_write(12'h810, 16'h8888);
    check_cfg("R8");
    do_read("R8", 12'h905);
    do_read("R8", 12'hF05);
    do_read("R8", 12'h310);
    do_read("R8", 12'h8FF);

    // random traffic covering R2..R8
    for (int i = 0; i < 4000; i++) begin
      logic [11:0] a;
      a = rand_addr();
      if ($urandom_range(0, 1) == 0)
        do_write(a, 16'($urandom()));
      else
        do_read("R2/R4/R7/R8 random", a);
      if (i % 500 == 499) check_cfg("R3/R6 random");
    end

    // R1: hard reset mid-run
    do_write(12'h800, 16'h0001);
    @(negedge clk);
    rst_n = 1'b0;
    model_hard_reset();
    @(negedge clk);
    check("R1", rd_data, 16'h0);
    check_cfg("R1");
    rst_n = 1'b1;
    do_read("R1", 12'hF00);
    do_read("R1", 12'h003);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #1_500_000;
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule